// File: doc/BRIEF.md
# Registered Narrow-to-Wide Bus Exchanger

This block moves data between a narrow port A and a wide port made of two
narrow halves, called 1B and 2B. From A to the wide port it collects two
narrow words that arrive one after the other. It then shows them side by side,
so the wide bus sees one double-width word. The first word appears on 1B and
the second on 2B. From the wide port back to A, each half has its own capture
register. A select input, sampled on the clock, decides which captured half
drives A.

Every storage register has its own active-low load enable. The A-to-1B path has
two register stages and the A-to-2B path has one, which keeps the two words in
step. Each port has an active-low output enable, and that enable is registered.
A direction change therefore takes effect on a clock edge. The ports are plain
input, output and drive-flag signals, not tristate pads. Reset is asynchronous
and active low.

Top module: `nwx_bus_exchanger`

## Requirements
- R1: While reset is active, all data outputs are zero and both drive flags are low.
- R2: A word on `a_in` reaches `b1_out` after two rising edges when `a1_load_n` is low at both edges.
- R3: A word on `a_in` reaches `b2_out` one rising edge after an edge where `a2_load_n` is low.
- R4: When `a1_load_n` is high at an edge, both stages of the A-to-1B path keep their values, so `b1_out` is unchanged.
- R5: When `a2_load_n` is high at an edge, `b2_out` is unchanged.
- R6: Two steps place two consecutive A words together on the wide bus, as {`b2_out`,`b1_out`} = {second, first}. In the first step `a1_load_n` is low. In the second step both `a1_load_n` and `a2_load_n` are low.
- R7: The 1B capture register loads `b1_in` only at an edge where `b1_load_n` is low. The 2B capture register loads `b2_in` only at an edge where `b2_load_n` is low. Otherwise each keeps its value.
- R8: `sel_1b` is sampled at each rising edge. If the sampled value is 1, `a_out` shows the 1B capture register. If it is 0, `a_out` shows the 2B capture register.
- R9: `a_drv` equals the inverse of `a_oe_n` sampled at the previous rising edge, and `b_drv` equals the inverse of `b_oe_n` sampled at that edge. All four enable combinations are valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | W | Narrow port input data |
| a_out | output | W | Narrow port output data (selected half) |
| a_drv | output | 1 | Narrow port drive flag |
| b1_in | input | W | Wide port lower half input |
| b2_in | input | W | Wide port upper half input |
| b1_out | output | W | Wide port lower half output (first word) |
| b2_out | output | W | Wide port upper half output (second word) |
| b_drv | output | 1 | Wide port drive flag |
| a1_load_n | input | 1 | Active-low load for both A-to-1B stages |
| a2_load_n | input | 1 | Active-low load for the A-to-2B register |
| b1_load_n | input | 1 | Active-low load for the 1B capture register |
| b2_load_n | input | 1 | Active-low load for the 2B capture register |
| sel_1b | input | 1 | Return select: 1 picks 1B, 0 picks 2B |
| a_oe_n | input | 1 | Active-low output enable for port A |
| b_oe_n | input | 1 | Active-low output enable for port B |

## Verification
The bench drives random data and random load enables every cycle and compares
the outputs against a cycle-accurate model. This shows whether each path has the
correct number of stages and whether each enable gates only its own register.
Directed sequences then load a word pair and hold it while A keeps changing.
This separates a correct two-word alignment from a path that follows A
continuously. Further directed cases capture one B half, then flip the select and
its load enable separately. This shows whether the select is registered and
whether the halves are kept apart. All four output-enable combinations are also
stepped through to check the one-edge delay on each drive flag.

// File: rtl/nwx_pkg.sv
package nwx_pkg;
  localparam int NWX_HALVES = 2;
  localparam int IDX_1B     = 0;
  localparam int IDX_2B     = 1;
  typedef enum logic {
    PICK_2B = 1'b0,
    PICK_1B = 1'b1
  } half_pick_e;
endpackage

// File: rtl/nwx_gather.sv
module nwx_gather #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  input  logic         ld1_n,
  input  logic         ld2_n,
  output logic [W-1:0] b1_q,
  output logic [W-1:0] b2_q
);
  logic [W-1:0] stg1_q, stg1_d, b1_d, b2_d;

  always_comb begin
    stg1_d = stg1_q;
    b1_d   = b1_q;
    b2_d   = b2_q;
    if (!ld1_n) begin
      stg1_d = a_in;
      b1_d   = stg1_q;
    end
    if (!ld2_n) begin
      b2_d = a_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg1_q <= '0;
      b1_q   <= '0;
      b2_q   <= '0;
    end else begin
      stg1_q <= stg1_d;
      b1_q   <= b1_d;
      b2_q   <= b2_d;
    end
  end

  AST_B1_TWO_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n, 2) && $past(rst_n) && !$past(ld1_n, 2) && !$past(ld1_n))
      |-> b1_q == $past(a_in, 2)); // R2
  AST_B2_ONE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(ld2_n)) |-> b2_q == $past(a_in)); // R3
  AST_B1_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(ld1_n)) |-> $stable(b1_q)); // R4
  AST_B2_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(ld2_n)) |-> $stable(b2_q)); // R5
endmodule

// File: rtl/nwx_return.sv
module nwx_return
  import nwx_pkg::*;
#(
  parameter int W = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NWX_HALVES-1:0][W-1:0] b_in,
  input  logic [NWX_HALVES-1:0]      ld_n,
  input  logic                       sel_1b,
  output logic [W-1:0]               a_q
);
  logic [NWX_HALVES-1:0][W-1:0] cap_q;
  half_pick_e pick_q, pick_d;

  for (genvar h = 0; h < NWX_HALVES; h++) begin : g_cap
    logic [W-1:0] cap_d;
    always_comb begin
      cap_d = cap_q[h];
      if (!ld_n[h]) cap_d = b_in[h];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cap_q[h] <= '0;
      else        cap_q[h] <= cap_d;
    end
    AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(ld_n[h])) |-> $stable(cap_q[h])); // R7
  end

  always_comb pick_d = sel_1b ? PICK_1B : PICK_2B;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pick_q <= PICK_2B;
    else        pick_q <= pick_d;
  end

  assign a_q = (pick_q == PICK_1B) ? cap_q[IDX_1B] : cap_q[IDX_2B];

  AST_SEL_1B: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(sel_1b)) |-> a_q == cap_q[IDX_1B]); // R8
  AST_SEL_2B: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(sel_1b)) |-> a_q == cap_q[IDX_2B]); // R8
endmodule

// File: rtl/nwx_drive.sv
module nwx_drive #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] oe_n,
  output logic [N-1:0] drv
);
  for (genvar p = 0; p < N; p++) begin : g_port
    logic drv_d;
    always_comb drv_d = ~oe_n[p];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) drv[p] <= 1'b0;
      else        drv[p] <= drv_d;
    end
    AST_DRV_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> drv[p] == !$past(oe_n[p])); // R9
  end
endmodule

// File: rtl/nwx_bus_exchanger.sv
module nwx_bus_exchanger
  import nwx_pkg::*;
#(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_drv,
  input  logic [W-1:0] b1_in,
  input  logic [W-1:0] b2_in,
  output logic [W-1:0] b1_out,
  output logic [W-1:0] b2_out,
  output logic         b_drv,
  input  logic         a1_load_n,
  input  logic         a2_load_n,
  input  logic         b1_load_n,
  input  logic         b2_load_n,
  input  logic         sel_1b,
  input  logic         a_oe_n,
  input  logic         b_oe_n
);
  logic [NWX_HALVES-1:0][W-1:0] b_bus;
  logic [NWX_HALVES-1:0]        b_ld_n;
  logic [1:0]                   oe_n_v, drv_v;

  assign b_bus[IDX_1B]  = b1_in;
  assign b_bus[IDX_2B]  = b2_in;
  assign b_ld_n[IDX_1B] = b1_load_n;
  assign b_ld_n[IDX_2B] = b2_load_n;
  assign oe_n_v         = {b_oe_n, a_oe_n};
  assign a_drv          = drv_v[0];
  assign b_drv          = drv_v[1];

  nwx_gather #(.W(W)) u_gather (
    .clk(clk), .rst_n(rst_n), .a_in(a_in),
    .ld1_n(a1_load_n), .ld2_n(a2_load_n),
    .b1_q(b1_out), .b2_q(b2_out)
  );

  nwx_return #(.W(W)) u_return (
    .clk(clk), .rst_n(rst_n), .b_in(b_bus), .ld_n(b_ld_n),
    .sel_1b(sel_1b), .a_q(a_out)
  );

  nwx_drive #(.N(2)) u_drive (
    .clk(clk), .rst_n(rst_n), .oe_n(oe_n_v), .drv(drv_v)
  );

  AST_PAIR_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n, 2) && $past(rst_n) && !$past(a1_load_n, 2)
     && !$past(a1_load_n) && !$past(a2_load_n))
      |-> {b2_out, b1_out} == {$past(a_in), $past(a_in, 2)}); // R6
endmodule

// File: tb/test_nwx_bus_exchanger.sv
`timescale 1ns/1ps
module test_nwx_bus_exchanger;
  localparam int W = 12;
  logic clk = 1'b0;
  logic rst_n;
  logic [W-1:0] a_in, b1_in, b2_in;
  logic a1_load_n, a2_load_n, b1_load_n, b2_load_n, sel_1b, a_oe_n, b_oe_n;
  logic [W-1:0] a_out, b1_out, b2_out;
  logic a_drv, b_drv;
  int n_run = 0, n_fail = 0;

  // model state
  logic [W-1:0] m_s1, m_b1, m_b2, m_r1, m_r2;
  logic m_sel, m_ad, m_bd;

  always #2.5 clk = ~clk;

  nwx_bus_exchanger #(.W(W)) i_nwx_bus_exchanger (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .a_out(a_out), .a_drv(a_drv),
    .b1_in(b1_in), .b2_in(b2_in), .b1_out(b1_out), .b2_out(b2_out),
    .b_drv(b_drv), .a1_load_n(a1_load_n), .a2_load_n(a2_load_n),
    .b1_load_n(b1_load_n), .b2_load_n(b2_load_n), .sel_1b(sel_1b),
    .a_oe_n(a_oe_n), .b_oe_n(b_oe_n)
  );

  function automatic logic [W-1:0] exp_a(logic s, logic [W-1:0] r1, logic [W-1:0] r2);
    return s ? r1 : r2;
  endfunction

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_s1 = '0; m_b1 = '0; m_b2 = '0; m_r1 = '0; m_r2 = '0;
    m_sel = 1'b0; m_ad = 1'b0; m_bd = 1'b0;
  endtask

  // advance one edge: model follows current inputs, then compare
  task automatic step();
    logic [W-1:0] n_s1, n_b1, n_b2, n_r1, n_r2;
    n_s1 = a1_load_n ? m_s1 : a_in;
    n_b1 = a1_load_n ? m_b1 : m_s1;
    n_b2 = a2_load_n ? m_b2 : a_in;
    n_r1 = b1_load_n ? m_r1 : b1_in;
    n_r2 = b2_load_n ? m_r2 : b2_in;
    m_sel = sel_1b; m_ad = ~a_oe_n; m_bd = ~b_oe_n;
    m_s1 = n_s1; m_b1 = n_b1; m_b2 = n_b2; m_r1 = n_r1; m_r2 = n_r2;
    @(posedge clk); #1;
    chk("R2 b1_out", b1_out, m_b1);
    chk("R3 b2_out", b2_out, m_b2);
    chk("R8 a_out", a_out, exp_a(m_sel, m_r1, m_r2));
    chk("R9 a_drv", {{(W-1){1'b0}}, a_drv}, {{(W-1){1'b0}}, m_ad});
    chk("R9 b_drv", {{(W-1){1'b0}}, b_drv}, {{(W-1){1'b0}}, m_bd});
  endtask

  task automatic idle();
    a1_load_n = 1; a2_load_n = 1; b1_load_n = 1; b2_load_n = 1;
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [W-1:0] w0, w1, x1;
    void'($urandom(32'd4242));
    rst_n = 0; a_in = '1; b1_in = '1; b2_in = '1;
    a1_load_n = 0; a2_load_n = 0; b1_load_n = 0; b2_load_n = 0;
    sel_1b = 1; a_oe_n = 0; b_oe_n = 0;
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    // R1: reset holds everything at zero
    chk("R1 a_out", a_out, '0);
    chk("R1 b1_out", b1_out, '0);
    chk("R1 b2_out", b2_out, '0);
    chk("R1 drv", {{(W-2){1'b0}}, a_drv, b_drv}, '0);
    rst_n = 1;

    // R6: word pair alignment, then R4/R5 hold while A keeps moving
    w0 = 12'h3A5; w1 = 12'hC5A;
    idle(); a_oe_n = 1; b_oe_n = 0;
    a_in = w0; a1_load_n = 0; step();
    a_in = w1; a1_load_n = 0; a2_load_n = 0; step();
    chk("R6 pair", b1_out, w0);
    chk("R6 pair", b2_out, w1);
    idle();
    for (int i = 0; i < 4; i++) begin
      a_in = W'($urandom); step();
      chk("R4 hold b1", b1_out, w0);
      chk("R5 hold b2", b2_out, w1);
    end

    // R7: capture 1B, then ignore later 1B input while load is high
    x1 = 12'h7E1;
    b1_in = x1; b1_load_n = 0; sel_1b = 1; step();
    b1_load_n = 1; b1_in = ~x1; step();
    chk("R7 1B hold", a_out, x1);
    b2_in = 12'h0F0; b2_load_n = 0; sel_1b = 0; step();
    b2_load_n = 1; b2_in = 12'h111; step();
    chk("R7 2B hold", a_out, 12'h0F0);
    // R8: select is registered; change takes effect after one edge
    sel_1b = 1;
    #1 chk("R8 sel registered", a_out, 12'h0F0);
    step();
    chk("R8 sel 1B", a_out, x1);

    // R9: all four enable combinations
    for (int c = 0; c < 4; c++) begin
      a_oe_n = c[0]; b_oe_n = c[1];
      #1 chk("R9 no early change", {{(W-1){1'b0}}, a_drv}, {{(W-1){1'b0}}, m_ad});
      step();
    end

    // random traffic against the model
    for (int i = 0; i < 400; i++) begin
      a_in = W'($urandom); b1_in = W'($urandom); b2_in = W'($urandom);
      a1_load_n = $urandom % 2; a2_load_n = $urandom % 2;
      b1_load_n = $urandom % 2; b2_load_n = $urandom % 2;
      sel_1b = $urandom % 2; a_oe_n = $urandom % 2; b_oe_n = $urandom % 2;
      step();
    end

    // R1: asynchronous reset in mid traffic
    rst_n = 0; #1;
    chk("R1 mid reset b1", b1_out, '0);
    chk("R1 mid reset a", a_out, '0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule